// File: doc/BRIEF.md
# Debug Variable Capture Unit

This unit takes the place of one storage register in a design so that the register can be watched and steered while the design runs. The producer logic drives the next value in, and the consumers read the unit's output as if it were the plain register. On every cycle where the design clock enable is high, the unit loads the next value and also writes it into a 16-entry circular history held in local registers.

A small request/response debug port lets a controller do several things. It can read the live value, or the value from a given number of loads back. It can force a new value once or until it is released, after which the design carries on from the forced value. It can also rewind the register to an earlier recorded value, as long as that value is still inside the history. A near-full flag warns the controller that the history is close to wrapping, so it can stall the design before older entries are overwritten. Because the unit is the register itself, a rewind restores state-machine state directly.

Top module: `dbg_var_unit`

## Requirements
- R1: On a rising clock edge with `ce` high, no active force and no accepted rewind, `cons_val` takes the value of `prod_val`. With `ce` low and no accepted rewind, `cons_val` holds.
- R2: A request (`dbg_req` high for one cycle) is answered by `dbg_ack` high exactly one cycle later. Op code 0 (read live) returns the `cons_val` present at the request, with `dbg_err` low.
- R3: Op code 1 (read history) with depth d in `dbg_arg` returns the value loaded d loads ago (d=0 is the newest load). If d is not below `hist_cnt`, the unit answers with `dbg_err` high and `dbg_rdata` 0.
- R4: Every load raises `hist_cnt` by one, up to a ceiling of DEPTH (16). Once full, each new load replaces the oldest entry.
- R5: Op code 2 (force once) with `dbg_wdata` makes the next enabled load take that value instead of `prod_val`. Later loads take `prod_val` again, and the forced value is recorded in the history.
- R6: Op code 3 (force sticky) makes every enabled load take `dbg_wdata`. Op code 4 (release) ends that, after which `prod_val` is loaded again.
- R7: Op code 5 (rewind) with n in `dbg_arg`, where 1 <= n < `hist_cnt`, sets `cons_val` at the request edge to the value loaded n loads ago. It lowers `hist_cnt` by n and makes that value the newest history entry. A rewind takes precedence over a load in the same cycle, and `dbg_rdata` returns the restored value.
- R8: A rewind with n = 0 or n >= `hist_cnt` is rejected with `dbg_err` high. `cons_val` and `hist_cnt` are left unchanged.
- R9: `near_full` is high exactly when `hist_cnt` >= NF_TH (12).
- R10: After reset, `cons_val` is 0, `hist_cnt` is 0, `near_full` and `dbg_ack` are low, and no force is active.
- R11: Op codes 6 and 7 are answered with `dbg_err` high and have no effect on `cons_val` or `hist_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Design clock enable; a load happens only when high |
| prod_val | input | W | Next value from the producer logic |
| cons_val | output | W | Register value seen by consumers |
| dbg_req | input | 1 | Debug request strobe |
| dbg_op | input | 3 | Request op code (0..5 valid) |
| dbg_arg | input | AW | History depth or rewind distance |
| dbg_wdata | input | W | Value for force requests |
| dbg_ack | output | 1 | Response strobe, one cycle after the request |
| dbg_err | output | 1 | Request rejected |
| dbg_rdata | output | W | Read or restored value |
| hist_cnt | output | CW | Number of valid history entries |
| near_full | output | 1 | History has reached the stall threshold |

## Verification
A wrong write pointer shows up in the very next history read as a value from the wrong depth, and any rewind then restores that same wrong value straight onto `cons_val`. A wrong history count shows up as a read or rewind that is accepted or rejected on the wrong side of the boundary, and as `near_full` rising one load early or late. A stuck force register shows up at the first enabled load after a release or after a one-shot force, when `cons_val` fails to follow `prod_val`.

// File: rtl/dvu_pkg.sv
package dvu_pkg;

  typedef enum logic [2:0] {
    OP_RD_CUR       = 3'd0,
    OP_RD_HIST      = 3'd1,
    OP_FORCE_ONCE   = 3'd2,
    OP_FORCE_STICKY = 3'd3,
    OP_RELEASE      = 3'd4,
    OP_REWIND       = 3'd5
  } dbg_op_e;

  // slot n positions behind wp in a ring of the given depth
  function automatic int ring_sub(int wp, int n, int depth);
    return (wp + depth - n) % depth;
  endfunction

  function automatic int ring_inc(int wp, int depth);
    return (wp + 1) % depth;
  endfunction

  // valid-entry count after one load, saturating at depth
  function automatic int cnt_after_load(int c, int depth);
    return (c >= depth) ? depth : c + 1;
  endfunction

  function automatic bit depth_ok(int d, int c);
    return d < c;
  endfunction

  function automatic bit rewind_ok(int n, int c);
    return (n >= 1) && (n < c);
  endfunction

endpackage

// File: rtl/dvu_history.sv
module dvu_history #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [W-1:0]  load_val,
  input  logic          rw_en,
  input  logic [AW-1:0] rd_ofs,
  output logic [W-1:0]  rd_val,
  output logic [CW-1:0] cnt
);
  import dvu_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rd_idx;

  // rd_ofs = 0 addresses the newest entry
  assign rd_idx = AW'(ring_sub(int'(wptr), int'(rd_ofs) + 1, DEPTH));
  assign rd_val = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      cnt  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (rw_en) begin
      wptr <= AW'(ring_sub(int'(wptr), int'(rd_ofs), DEPTH));
      cnt  <= cnt - CW'(rd_ofs);
    end else if (load_en) begin
      mem[wptr] <= load_val;
      wptr      <= AW'(ring_inc(int'(wptr), DEPTH));
      cnt       <= CW'(cnt_after_load(int'(cnt), DEPTH));
    end
  end

endmodule

// File: rtl/dvu_override.sv
module dvu_override #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         set_once,
  input  logic         set_sticky,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] prod_val,
  output logic [W-1:0] next_val,
  output logic         once_pend,
  output logic         sticky_on,
  output logic [W-1:0] sticky_val
);

  logic [W-1:0] once_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      once_pend  <= 1'b0;
      once_val   <= '0;
      sticky_on  <= 1'b0;
      sticky_val <= '0;
    end else if (clr) begin
      once_pend <= 1'b0;
      sticky_on <= 1'b0;
    end else begin
      if (set_sticky) begin
        sticky_on  <= 1'b1;
        sticky_val <= wdata;
      end
      if (set_once) begin
        once_pend <= 1'b1;
        once_val  <= wdata;
      end else if (take) begin
        once_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    if (sticky_on)      next_val = sticky_val;
    else if (once_pend) next_val = once_val;
    else                next_val = prod_val;
  end

endmodule

// File: rtl/dvu_dbg_port.sv
module dvu_dbg_port #(
  parameter int W  = 8,
  parameter int AW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    op,
  input  logic [AW-1:0] arg,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  cur_val,
  input  logic [W-1:0]  hist_val,
  output logic          rw_fire,
  output logic          set_once,
  output logic          set_sticky,
  output logic          clr,
  output logic          ack,
  output logic          err,
  output logic [W-1:0]  rdata
);
  import dvu_pkg::*;

  logic         bad;
  logic [W-1:0] rsp_val;

  always_comb begin
    rw_fire    = 1'b0;
    set_once   = 1'b0;
    set_sticky = 1'b0;
    clr        = 1'b0;
    bad        = 1'b0;
    rsp_val    = '0;
    if (req) begin
      case (op)
        3'(OP_RD_CUR):       rsp_val = cur_val;
        3'(OP_RD_HIST): begin
          if (depth_ok(int'(arg), int'(cnt))) rsp_val = hist_val;
          else                                bad     = 1'b1;
        end
        3'(OP_FORCE_ONCE):   set_once   = 1'b1;
        3'(OP_FORCE_STICKY): set_sticky = 1'b1;
        3'(OP_RELEASE):      clr        = 1'b1;
        3'(OP_REWIND): begin
          if (rewind_ok(int'(arg), int'(cnt))) begin
            rw_fire = 1'b1;
            rsp_val = hist_val;
          end else begin
            bad = 1'b1;
          end
        end
        default:             bad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      err   <= bad;
      rdata <= rsp_val;
    end
  end

endmodule

// File: rtl/dbg_var_unit.sv
module dbg_var_unit #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int NF_TH = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [W-1:0]  prod_val,
  output logic [W-1:0]  cons_val,
  input  logic          dbg_req,
  input  logic [2:0]    dbg_op,
  input  logic [AW-1:0] dbg_arg,
  input  logic [W-1:0]  dbg_wdata,
  output logic          dbg_ack,
  output logic          dbg_err,
  output logic [W-1:0]  dbg_rdata,
  output logic [CW-1:0] hist_cnt,
  output logic          near_full
);

  logic [W-1:0] cur;
  logic [W-1:0] next_val;
  logic [W-1:0] hist_val;
  logic [W-1:0] sticky_val;
  logic         rw_fire;
  logic         load_en;
  logic         set_once;
  logic         set_sticky;
  logic         clr;
  logic         once_pend;
  logic         sticky_on;

  assign load_en   = ce & ~rw_fire;
  assign cons_val  = cur;
  assign near_full = (hist_cnt >= CW'(NF_TH));

  dvu_dbg_port #(.W(W), .AW(AW), .CW(CW)) u_port (
    .clk(clk), .rst_n(rst_n), .req(dbg_req), .op(dbg_op), .arg(dbg_arg),
    .cnt(hist_cnt), .cur_val(cur), .hist_val(hist_val),
    .rw_fire(rw_fire), .set_once(set_once), .set_sticky(set_sticky), .clr(clr),
    .ack(dbg_ack), .err(dbg_err), .rdata(dbg_rdata)
  );

  dvu_override #(.W(W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .take(load_en), .set_once(set_once),
    .set_sticky(set_sticky), .clr(clr), .wdata(dbg_wdata), .prod_val(prod_val),
    .next_val(next_val), .once_pend(once_pend), .sticky_on(sticky_on),
    .sticky_val(sticky_val)
  );

  dvu_history #(.W(W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_hist (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(next_val),
    .rw_en(rw_fire), .rd_ofs(dbg_arg), .rd_val(hist_val), .cnt(hist_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= '0;
    else if (rw_fire) cur <= hist_val;
    else if (load_en) cur <= next_val;
  end

endmodule

// File: rtl/dvu_checker.sv
module dvu_checker #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int NF_TH = 12,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic [W-1:0]  prod_val,
  input logic [W-1:0]  cons_val,
  input logic          dbg_req,
  input logic [2:0]    dbg_op,
  input logic [AW-1:0] dbg_arg,
  input logic          dbg_ack,
  input logic          dbg_err,
  input logic [CW-1:0] hist_cnt,
  input logic          near_full,
  input logic          rw_fire,
  input logic          load_en,
  input logic          once_pend,
  input logic          sticky_on,
  input logic [W-1:0]  sticky_val
);

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && !sticky_on && !once_pend |=> cons_val == $past(prod_val)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce && !rw_fire |=> $stable(cons_val)); // R1
  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |=> dbg_ack); // R2
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_req |=> !dbg_ack); // R2
  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    hist_cnt <= CW'(DEPTH)); // R4
  AST_STICKY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && sticky_on |=> cons_val == $past(sticky_val)); // R6
  AST_REWIND_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    rw_fire |=> hist_cnt == $past(hist_cnt) - CW'($past(dbg_arg))); // R7
  AST_REWIND_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req && dbg_op == 3'd5 && (dbg_arg == '0 || CW'(dbg_arg) >= hist_cnt)
    |=> dbg_err); // R8
  AST_NF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(near_full) |-> $past(load_en)); // R9
  AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req && dbg_op > 3'd5 |=> dbg_err); // R11

endmodule

bind dbg_var_unit dvu_checker #(.W(W), .DEPTH(DEPTH), .NF_TH(NF_TH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .prod_val(prod_val), .cons_val(cons_val),
  .dbg_req(dbg_req), .dbg_op(dbg_op), .dbg_arg(dbg_arg), .dbg_ack(dbg_ack),
  .dbg_err(dbg_err), .hist_cnt(hist_cnt), .near_full(near_full),
  .rw_fire(rw_fire), .load_en(load_en), .once_pend(once_pend),
  .sticky_on(sticky_on), .sticky_val(sticky_val)
);

// File: tb/tb_dbg_var_unit.sv
module tb_dbg_var_unit;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0;
  logic [7:0] prod_val = '0;
  logic [7:0] cons_val;
  logic       dbg_req = 1'b0;
  logic [2:0] dbg_op = '0;
  logic [3:0] dbg_arg = '0;
  logic [7:0] dbg_wdata = '0;
  logic       dbg_ack, dbg_err;
  logic [7:0] dbg_rdata;
  logic [4:0] hist_cnt;
  logic       near_full;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dbg_var_unit dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .prod_val(prod_val), .cons_val(cons_val),
    .dbg_req(dbg_req), .dbg_op(dbg_op), .dbg_arg(dbg_arg), .dbg_wdata(dbg_wdata),
    .dbg_ack(dbg_ack), .dbg_err(dbg_err), .dbg_rdata(dbg_rdata),
    .hist_cnt(hist_cnt), .near_full(near_full)
  );

  // {ce, prod_val, expected cons_val after the edge}
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 8'h11, 8'h11}, {1'b1, 8'h22, 8'h22}, {1'b0, 8'h33, 8'h22},
    {1'b1, 8'h44, 8'h44}, {1'b1, 8'h55, 8'h55}, {1'b0, 8'h66, 8'h55},
    {1'b1, 8'h77, 8'h77}, {1'b1, 8'h88, 8'h88}, {1'b1, 8'h99, 8'h99},
    {1'b1, 8'hA0, 8'hA0}
  };

  task automatic check(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [3:0] arg,
                       input logic [7:0] wd, input logic with_ce = 1'b0,
                       input logic [7:0] pv = 8'h00);
    @(negedge clk);
    dbg_req = 1'b1; dbg_op = op; dbg_arg = arg; dbg_wdata = wd;
    ce = with_ce; prod_val = pv;
    @(negedge clk);
    dbg_req = 1'b0; ce = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    ce = 1'b1; prod_val = v;
    @(negedge clk);
    ce = 1'b0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 cons", cons_val, 0);
    check("R10 cnt", hist_cnt, 0);
    check("R10 near_full", near_full, 0);
    check("R10 ack", dbg_ack, 0);
    do_op(3'd1, 4'd0, 8'h00);
    check("R3 empty read err", dbg_err, 1);
    check("R2 ack", dbg_ack, 1);

    // R1 table walk
    for (int i = 0; i < 10; i++) begin
      ce = VEC[i][16]; prod_val = VEC[i][15:8];
      @(negedge clk);
      check("R1 table", cons_val, int'(VEC[i][7:0]));
    end
    ce = 1'b0;
    check("R4 count", hist_cnt, 8);

    do_op(3'd0, 4'd0, 8'h00);
    check("R2 read live", dbg_rdata, 8'hA0);
    check("R2 no err", dbg_err, 0);
    do_op(3'd1, 4'd3, 8'h00);
    check("R3 depth3", dbg_rdata, 8'h77);
    do_op(3'd1, 4'd7, 8'h00);
    check("R3 depth7", dbg_rdata, 8'h11);
    do_op(3'd1, 4'd8, 8'h00);
    check("R3 beyond err", dbg_err, 1);
    check("R3 beyond data", dbg_rdata, 0);

    // R7 rewind by 2
    do_op(3'd5, 4'd2, 8'h00);
    check("R7 ok", dbg_err, 0);
    check("R7 restored data", dbg_rdata, 8'h88);
    check("R7 cons", cons_val, 8'h88);
    check("R7 cnt", hist_cnt, 6);
    do_op(3'd1, 4'd1, 8'h00);
    check("R7 history shifted", dbg_rdata, 8'h77);

    // R8 rejects
    do_op(3'd5, 4'd6, 8'h00);
    check("R8 n>=cnt err", dbg_err, 1);
    do_op(3'd5, 4'd0, 8'h00);
    check("R8 n=0 err", dbg_err, 1);
    check("R8 cons kept", cons_val, 8'h88);
    check("R8 cnt kept", hist_cnt, 6);

    // R11 unused op
    do_op(3'd6, 4'd1, 8'hEE);
    check("R11 err", dbg_err, 1);
    check("R11 cons kept", cons_val, 8'h88);
    check("R11 cnt kept", hist_cnt, 6);

    // R5 one-shot
    do_op(3'd2, 4'd0, 8'h5A);
    load(8'h10);
    check("R5 forced", cons_val, 8'h5A);
    load(8'h20);
    check("R5 resumed", cons_val, 8'h20);
    do_op(3'd1, 4'd1, 8'h00);
    check("R5 recorded", dbg_rdata, 8'h5A);

    // R6 sticky
    do_op(3'd3, 4'd0, 8'hC3);
    load(8'h30);
    check("R6 sticky 1", cons_val, 8'hC3);
    load(8'h31);
    check("R6 sticky 2", cons_val, 8'hC3);
    do_op(3'd4, 4'd0, 8'h00);
    load(8'h32);
    check("R6 released", cons_val, 8'h32);

    // R9 threshold
    check("R9 cnt 11", hist_cnt, 11);
    check("R9 below", near_full, 0);
    load(8'h40);
    check("R9 at 12", near_full, 1);

    // R4 saturation and overwrite
    for (int i = 0; i < 20; i++) load(8'(8'h80 + i));
    check("R4 saturated", hist_cnt, 16);
    do_op(3'd1, 4'd15, 8'h00);
    check("R4 oldest", dbg_rdata, 8'h84);

    // R7 rewind wins over same-cycle load
    do_op(3'd5, 4'd1, 8'h00, 1'b1, 8'hFF);
    check("R7 precedence cons", cons_val, 8'h92);
    check("R7 precedence cnt", hist_cnt, 15);

    done = 1;
    summary();
    $finish;
  end

endmodule